// File: doc/BRIEF.md
# Zero-Order-Hold Droop Compensation FIR

This block sharpens the high-frequency end of a sampled waveform before it reaches a converter whose zero-order hold rolls the spectrum off as sin(x)/x. It is a fixed, mirror-symmetric nine-tap FIR that takes one signed 16-bit sample per accepted input and returns one filtered sample. The result is divided by 512, rounded and clamped to 16 bits. A chip uses one copy on the in-phase path and one on the quadrature path.

A one-bit enable register, loaded through a write strobe, chooses between the filtered result and a plain copy of the input. The register clears on reset, so the block starts out as a pass-through. Both choices leave the block through the same number of register stages, so switching the filter in or out does not shift the output in time. Input samples qualified by a valid flag advance the tap history. Idle cycles leave the history and the output untouched.

Top module: `zoh_comp_fir`

## Requirements
- R1: While reset is asserted and right after it is released, out_vld is 0, out_data is 0 and the enable register is 0.
- R2: With the enable register at 0, every accepted sample appears unchanged on out_data.
- R3: A cycle with en_wr high loads en_val into the enable register at that edge. A value of 1 routes the filtered result to the output and a value of 0 routes the bypass copy. Samples reaching the output stage use the register's value at that point.
- R4: With filtering on, a lone sample of amplitude A among zeros produces the sequence A*c/512 for c = 2, -4, 10, -35, 401, -35, 10, -4, 2. The newest sample has the weight of the first entry, and the fifth entry is the centre tap.
- R5: With filtering on, a constant input level L settles, after nine samples, to the rounded value of L*347/512.
- R6: The weighted sum S is reduced to floor((S + 256) / 512), which rounds exact halves toward plus infinity, and is then clamped to [-32768, 32767].
- R7: out_vld rises for exactly one cycle for each accepted sample, five rising edges after the edge that captured it, whether filtering is on or off.
- R8: Cycles with in_vld low neither shift the tap history nor change out_data, and they raise no out_vld.
- R9: Full-scale inputs whose signs line up with the coefficient signs give the exact peak result (gain 503/512) with no internal wraparound.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_wr | input | 1 | Write strobe for the enable register |
| en_val | input | 1 | Value written to the enable register (1 = filter, 0 = bypass) |
| in_vld | input | 1 | Marks in_data as a sample to accept |
| in_data | input | DATA_W (16) | Signed two's-complement input sample |
| out_vld | output | 1 | Marks out_data as a new result |
| out_data | output | DATA_W (16) | Signed filtered or bypassed sample |

## Verification
Every sample result is due on the fifth rising edge after the edge that captured the sample. The bench records the capture cycle with each expected value and checks both the value and the cycle distance at the falling edge after out_vld rises. An enable write is effective from the next edge, and mode changes are made only once the pipeline has drained, so each expected value depends on one known mode. The hold and no-advance behaviour is checked after a run of idle cycles carrying junk data: out_data must be unchanged, and the later valid samples must still match a history that excludes the junk.

// File: rtl/zoh_comp_pkg.sv
package zoh_comp_pkg;

   localparam int unsigned NTAPS = 9;
   localparam int unsigned NHALF = (NTAPS - 1) / 2;

   // Integer weight of tap k; taps mirror about the centre index NHALF.
   function automatic int tap_coef(input int unsigned k);
      int unsigned m;
      m = (k > NHALF) ? (NTAPS - 1 - k) : k;
      case (m)
         0:       return 2;
         1:       return -4;
         2:       return 10;
         3:       return -35;
         default: return 401;
      endcase
   endfunction

endpackage

// File: rtl/zoh_tap_line.sv
module zoh_tap_line #(
   parameter int unsigned DATA_W = 16,
   parameter int unsigned NTAPS  = 9
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         shift_en,
   input  logic [DATA_W-1:0]            din,
   output logic [NTAPS-1:0][DATA_W-1:0] taps
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         taps <= '0;
      end else if (shift_en) begin
         taps <= {taps[NTAPS-2:0], din};
      end
   end

endmodule

// File: rtl/zoh_fold_mac.sv
module zoh_fold_mac
   import zoh_comp_pkg::*;
#(
   parameter int unsigned DATA_W    = 16,
   parameter int unsigned COEF_W    = 10,
   parameter int unsigned ACC_W     = 31,
   parameter int unsigned PIPE_PROD = 1
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [NTAPS-1:0][DATA_W-1:0] taps,
   output logic signed [ACC_W-1:0]      acc
);

   localparam int unsigned SUM_W  = DATA_W + 1;
   localparam int unsigned PROD_W = SUM_W + COEF_W;

   logic [NHALF:0][PROD_W-1:0] prod_s;
   logic signed [ACC_W-1:0]    sum_c;

   for (genvar j = 0; j <= NHALF; j++) begin : g_lane
      localparam logic signed [COEF_W-1:0] CJ = COEF_W'(tap_coef(j));
      logic signed [SUM_W-1:0]  pre_q;
      logic signed [PROD_W-1:0] prod_c;

      if (j == NHALF) begin : g_centre
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pre_q <= '0;
            else        pre_q <= {taps[j][DATA_W-1], taps[j]};
         end
      end else begin : g_pair
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pre_q <= '0;
            else        pre_q <= {taps[j][DATA_W-1], taps[j]}
                               + {taps[NTAPS-1-j][DATA_W-1], taps[NTAPS-1-j]};
         end
      end

      assign prod_c = PROD_W'(pre_q) * PROD_W'(CJ);

      if (PIPE_PROD != 0) begin : g_preg
         logic signed [PROD_W-1:0] prod_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) prod_q <= '0;
            else        prod_q <= prod_c;
         end
         assign prod_s[j] = prod_q;
      end else begin : g_pcomb
         assign prod_s[j] = prod_c;
      end
   end

   always_comb begin
      sum_c = '0;
      for (int k = 0; k <= int'(NHALF); k++) begin
         sum_c = sum_c + ACC_W'(signed'(prod_s[k]));
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) acc <= '0;
      else        acc <= sum_c;
   end

endmodule

// File: rtl/zoh_norm_sat.sv
module zoh_norm_sat #(
   parameter int unsigned ACC_W  = 31,
   parameter int unsigned DATA_W = 16,
   parameter int unsigned SHIFT  = 9
) (
   input  logic signed [ACC_W-1:0] acc,
   output logic [DATA_W-1:0]       y
);

   localparam logic signed [ACC_W-1:0] HALF = ACC_W'(64'sd1 <<< (SHIFT - 1));
   localparam logic signed [ACC_W-1:0] MAXV = ACC_W'((64'sd1 <<< (DATA_W - 1)) - 64'sd1);
   localparam logic signed [ACC_W-1:0] MINV = ~MAXV;

   logic signed [ACC_W-1:0] rnd;
   logic signed [ACC_W-1:0] shr;

   assign rnd = acc + HALF;
   assign shr = rnd >>> SHIFT;

   always_comb begin
      if (shr > MAXV)      y = MAXV[DATA_W-1:0];
      else if (shr < MINV) y = MINV[DATA_W-1:0];
      else                 y = shr[DATA_W-1:0];
   end

endmodule

// File: rtl/zoh_comp_fir.sv
module zoh_comp_fir
   import zoh_comp_pkg::*;
#(
   parameter int unsigned DATA_W     = 16,
   parameter int unsigned COEF_W     = 10,
   parameter int unsigned NORM_SHIFT = 9,
   parameter int unsigned PIPE_PROD  = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en_wr,
   input  logic              en_val,
   input  logic              in_vld,
   input  logic [DATA_W-1:0] in_data,
   output logic              out_vld,
   output logic [DATA_W-1:0] out_data
);

   localparam int unsigned SUM_W   = DATA_W + 1;
   localparam int unsigned PROD_W  = SUM_W + COEF_W;
   localparam int unsigned ACC_W   = PROD_W + $clog2(NHALF + 1) + 1;
   localparam int unsigned MAC_LAT = (PIPE_PROD != 0) ? 3 : 2;
   localparam int unsigned LAT     = MAC_LAT + 2;

   if (DATA_W < 4) begin : g_bad_width
      $error("DATA_W must be at least 4");
   end
   if (COEF_W < 10) begin : g_bad_coef
      $error("COEF_W must hold the centre weight as a signed value");
   end
   if (NORM_SHIFT < 1 || NORM_SHIFT >= ACC_W) begin : g_bad_shift
      $error("NORM_SHIFT out of range");
   end

   logic                         en_q;
   logic                         vld_tap;
   logic [NTAPS-1:0][DATA_W-1:0] taps;
   logic [MAC_LAT-1:0]           vld_pipe;
   logic [MAC_LAT-1:0][DATA_W-1:0] byp_pipe;
   logic signed [ACC_W-1:0]      acc_w;
   logic [DATA_W-1:0]            y_w;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q    <= 1'b0;
         vld_tap <= 1'b0;
      end else begin
         if (en_wr) en_q <= en_val;
         vld_tap <= in_vld;
      end
   end

   zoh_tap_line #(.DATA_W(DATA_W), .NTAPS(NTAPS)) tap_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .shift_en (in_vld),
      .din      (in_data),
      .taps     (taps)
   );

   zoh_fold_mac #(
      .DATA_W(DATA_W), .COEF_W(COEF_W), .ACC_W(ACC_W), .PIPE_PROD(PIPE_PROD)
   ) mac_i (
      .clk   (clk),
      .rst_n (rst_n),
      .taps  (taps),
      .acc   (acc_w)
   );

   zoh_norm_sat #(.ACC_W(ACC_W), .DATA_W(DATA_W), .SHIFT(NORM_SHIFT)) norm_i (
      .acc (acc_w),
      .y   (y_w)
   );

   // Valid flag and bypass copy travel alongside the multiply-accumulate stages.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_pipe <= '0;
         byp_pipe <= '0;
      end else begin
         vld_pipe <= {vld_pipe[MAC_LAT-2:0], vld_tap};
         byp_pipe <= {byp_pipe[MAC_LAT-2:0], taps[0]};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_vld  <= 1'b0;
         out_data <= '0;
      end else begin
         out_vld <= vld_pipe[MAC_LAT-1];
         if (vld_pipe[MAC_LAT-1]) begin
            out_data <= en_q ? y_w : byp_pipe[MAC_LAT-1];
         end
      end
   end

endmodule

// File: rtl/zoh_comp_fir_chk.sv
module zoh_comp_fir_chk #(
   parameter int unsigned DATA_W = 16,
   parameter int unsigned LAT    = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              en_wr,
   input logic              en_val,
   input logic              in_vld,
   input logic [DATA_W-1:0] in_data,
   input logic              out_vld,
   input logic [DATA_W-1:0] out_data,
   input logic              en_q
);

   if (LAT > 14) begin : g_bad_lat
      $error("checker window counter too narrow for LAT");
   end

   logic [3:0] since_rst;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                since_rst <= '0;
      else if (since_rst != 4'hF) since_rst <= since_rst + 4'd1;
   end

   // R1
   reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!out_vld && out_data == '0 && !en_q));

   // R2
   bypass_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst >= 4'(LAT) && out_vld && !$past(en_q)) |-> (out_data == $past(in_data, LAT)));

   // R3
   en_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      en_wr |=> (en_q == $past(en_val)));

   // R7
   vld_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst >= 4'(LAT)) |-> (out_vld == $past(in_vld, LAT)));

   // R8
   out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst >= 4'd1 && !out_vld) |-> $stable(out_data));

endmodule

bind zoh_comp_fir zoh_comp_fir_chk #(.DATA_W(DATA_W), .LAT(LAT)) chk_i (
   .clk      (clk),
   .rst_n    (rst_n),
   .en_wr    (en_wr),
   .en_val   (en_val),
   .in_vld   (in_vld),
   .in_data  (in_data),
   .out_vld  (out_vld),
   .out_data (out_data),
   .en_q     (en_q)
);

// File: tb/zoh_comp_fir_tb_top.sv
module zoh_comp_fir_tb_top;

   localparam int DW  = 16;
   localparam int LAT = 5;

   logic          clk    = 1'b0;
   logic          rst_n  = 1'b0;
   logic          en_wr  = 1'b0;
   logic          en_val = 1'b0;
   logic          in_vld = 1'b0;
   logic [DW-1:0] in_data = '0;
   logic          out_vld;
   logic [DW-1:0] out_data;

   int checks = 0;
   int errors = 0;
   int cyc    = 0;
   bit done   = 1'b0;
   bit en_model = 1'b0;

   int coefs [9] = '{2, -4, 10, -35, 401, -35, 10, -4, 2};
   int hist  [9];
   int    exp_q [$];
   int    cyc_q [$];
   string tag_q [$];

   always #2.5 clk = ~clk;

   zoh_comp_fir dut_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .en_wr    (en_wr),
      .en_val   (en_val),
      .in_vld   (in_vld),
      .in_data  (in_data),
      .out_vld  (out_vld),
      .out_data (out_data)
   );

   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   // R6: floor((S + 256) / 512), then clamp to the signed 16-bit range.
   function automatic int model_filter();
      longint s = 0;
      for (int k = 0; k < 9; k++) s += longint'(coefs[k]) * longint'(hist[k]);
      s = (s + 256) >>> 9;
      if (s > 32767)  s = 32767;
      if (s < -32768) s = -32768;
      return int'(s);
   endfunction

   task automatic drive(input bit v, input int d, input string tag);
      @(negedge clk);
      in_vld  = v;
      in_data = d[DW-1:0];
      if (v) begin
         for (int k = 8; k > 0; k--) hist[k] = hist[k-1];
         hist[0] = d;
         exp_q.push_back(en_model ? model_filter() : d);
         cyc_q.push_back(cyc);
         tag_q.push_back(tag);
      end
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         in_vld  = 1'b0;
         in_data = DW'(16'hA5A5 ^ (i * 16'h1357));
      end
   endtask

   task automatic drain();
      while (exp_q.size() != 0) idle(1);
      idle(2);
   endtask

   task automatic set_en(input bit v);
      @(negedge clk);
      en_wr  = 1'b1;
      en_val = v;
      @(negedge clk);
      en_wr  = 1'b0;
      en_model = v;
   endtask

   always @(negedge clk) begin
      if (rst_n && out_vld) begin
         if (exp_q.size() == 0) begin
            check(1'b0, "R7 out_vld without an accepted sample", 1, 0);
         end else begin
            int e;
            int c;
            string t;
            e = exp_q.pop_front();
            c = cyc_q.pop_front();
            t = tag_q.pop_front();
            check($signed(out_data) == e, t, $signed(out_data), e);
            check(cyc - c == LAT, {t, " R7 latency"}, cyc - c, LAT);
         end
      end
   end

   initial begin
      for (int k = 0; k < 9; k++) hist[k] = 0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(out_vld == 1'b0, "R1 out_vld after reset", int'(out_vld), 0);
      check(out_data == '0, "R1 out_data after reset", $signed(out_data), 0);

      // R2: power-up bypass, sweep across the full input range
      for (int i = 0; i < 48; i++) drive(1'b1, -32768 + i * 1394, "R2 bypass sweep");
      drive(1'b1, 32767, "R2 bypass max");
      drive(1'b1, -32768, "R2 bypass min");
      drain();

      // R3: turn filtering on
      set_en(1'b1);

      // R4: impulse responses of both polarities
      foreach (coefs[a]) begin end
      for (int p = 0; p < 2; p++) begin
         for (int i = 0; i < 8; i++) drive(1'b1, 0, "R4 flush");
         drive(1'b1, (p == 0) ? 1024 : -1024, "R4 impulse");
         for (int i = 0; i < 10; i++) drive(1'b1, 0, "R4 impulse tail");
         drain();
      end

      // R6: impulses of 256 land exactly on half steps (-17.5 -> -17, 200.5 -> 201)
      for (int p = 0; p < 2; p++) begin
         for (int i = 0; i < 8; i++) drive(1'b1, 0, "R6 flush");
         drive(1'b1, (p == 0) ? 256 : -256, "R6 half rounding");
         for (int i = 0; i < 10; i++) drive(1'b1, 0, "R6 half rounding tail");
         drain();
      end

      // R5: step levels across the range settle to L*347/512
      for (int lvl = -32768; lvl <= 32767; lvl += 4099) begin
         for (int i = 0; i < 12; i++) drive(1'b1, lvl, "R5 step");
      end
      for (int i = 0; i < 12; i++) drive(1'b1, 32767, "R5 step max");
      drain();
      check(($signed(out_data) == ((32767 * 347 + 256) >>> 9)), "R5 settled dc gain",
            $signed(out_data), (32767 * 347 + 256) >>> 9);

      // R9: sign-aligned full-scale patterns, both polarities
      for (int p = 0; p < 2; p++) begin
         for (int k = 8; k >= 0; k--) begin
            bit pos;
            pos = (coefs[k] > 0) ^ (p == 1);
            drive(1'b1, pos ? 32767 : -32768, "R9 peak pattern");
         end
         for (int i = 0; i < 9; i++) drive(1'b1, 0, "R9 peak tail");
      end
      drain();

      // R8: idle cycles with junk data hold the output and the history
      begin
         int held;
         for (int i = 0; i < 5; i++) drive(1'b1, 3000 * i - 7000, "R8 preload");
         drain();
         held = $signed(out_data);
         idle(12);
         check($signed(out_data) == held, "R8 hold while idle", $signed(out_data), held);
         for (int i = 0; i < 60; i++)
            drive((i % 3) != 0, (i * 2741) % 65536 - 32768, "R8 gapped stream");
         drain();
      end

      // R3: writing 0 returns to bypass
      set_en(1'b0);
      for (int i = 0; i < 10; i++) drive(1'b1, i * 3001 - 15000, "R3 bypass after disable");
      drain();

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule